// File: doc/BRIEF.md
# Flash Command Sequencer with Block Lock Protection

This block is the control and status logic that sits between a CPU and an embedded flash array. The CPU writes a small control register and reads back a status byte. It issues four kinds of command: program, block erase, lock-bit program and lock-status query. The block decides whether each command may run. Accepted array operations go to the array as a one-cycle start pulse that carries an opcode and a block index. The block then waits for a one-cycle done pulse from the array, which carries a fail indication.

The block holds one lock bit per block, with 1 meaning unlocked and 0 meaning locked. It refuses program and erase on a locked block unless a lock-override control bit is set. An erase that succeeds while the override is set also unlocks the target block. A stop control bit holds the sequencer idle and keeps it away from the array. An area-select bit routes reads to the boot area or the user area, and only the user area accepts program and erase.

Top module: `flash_ctrl_seq`

## Requirements
- R1: After reset the status byte reads 0x10: control bits 0, ready 1, and both error flags and lock status 0. Every stored lock bit resets to 1 (unlocked).
- R2: The status byte has the following layout. Bit 0 is rewrite enable, bit 1 lock override, bit 2 stop and bit 3 user area. Bit 4 is ready, bit 5 program error, bit 6 erase error and bit 7 lock status. Control register writes load bits 3:0. Ready reads 0 from the cycle after a program, erase or lock-program start until the cycle after the array's done pulse. At all other times it reads 1.
- R3: A command is ignored when rewrite enable (bit 0) is 0. It is also ignored while stop (bit 2) is 1.
- R4: Program and erase are ignored when user area (bit 3) is 0. The `read_user_area` output follows that bit.
- R5: With lock override 0, a program or erase aimed at a locked block produces no start pulse and leaves ready at 1. It sets the matching error flag (program: bit 5, erase: bit 6) in the cycle after the command.
- R6: With lock override 1, program and erase on a locked block are started. Stored lock bits change only when an array operation completes.
- R7: An erase that was issued with lock override 1 and that completes without fail sets that block's lock bit to 1.
- R8: A lock-program command (opcode 2) that completes without fail clears the block's lock bit to 0. If it fails, it sets the program error flag.
- R9: A query command (opcode 3) copies the addressed block's lock bit into status bit 7 in the cycle after the command, with no array start. It needs rewrite enable but not the user area.
- R10: A done pulse with fail high sets the error flag that matches the operation (program or erase), and a done pulse with fail low clears it. Issuing a new program or erase command clears its own flag.
- R11: Commands that arrive while the sequencer is busy are dropped.
- R12: While stop is 1, the block forces ready to 1 on the next cycle and produces no start pulse.
- R13: An accepted array command gives a start pulse exactly one cycle wide in the cycle after the command. The pulse carries opcode 0 for program, 1 for erase or 2 for lock program, together with the command's block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control value: {user area, stop, lock override, rewrite enable} |
| reg_rdata | output | 8 | Status byte (layout in R2) |
| read_user_area | output | 1 | 1 routes reads to the user area, 0 to the boot area |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 0 program, 1 erase, 2 lock program, 3 query |
| cmd_blk | input | BW | Target block index |
| arr_start | output | 1 | One-cycle array start pulse |
| arr_op | output | 2 | Opcode sent with the start pulse |
| arr_blk | output | BW | Block index sent with the start pulse |
| arr_done | input | 1 | One-cycle completion pulse from the array |
| arr_fail | input | 1 | Failure indication, valid with arr_done |

## Verification
A lock bit that is wrong inside the block does not show at the ports by itself. It shows up in two ways. A query returns the wrong status bit 7 in the very next cycle. A program or erase on that block starts when it should be refused, or is refused when it should start, and the refusal also sets an error flag one cycle after the command. A busy state that is stuck or lost shows as ready bit 4 staying low after done. It also shows as a following command being dropped, or as a second start pulse during an operation. Both show up one cycle after the event that should have changed them. The bench therefore queries lock bits after every operation that could touch them, and it samples ready and the start pulse one cycle after each command and each done pulse.

// File: rtl/flash_ctrl_seq.sv
module flash_ctrl_seq #(
  parameter int NUM_BLOCKS = 8,
  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          read_user_area,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_blk,
  output logic          arr_start,
  output logic [1:0]    arr_op,
  output logic [BW-1:0] arr_blk,
  input  logic          arr_done,
  input  logic          arr_fail
);
  localparam logic [1:0] OP_PROG  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_LOCK  = 2'd2;
  localparam logic [1:0] OP_QUERY = 2'd3;

  logic                  en_q, lkoff_q, stop_q, user_q;
  logic                  busy_q, perr_q, eerr_q, lstat_q, unlock_q;
  logic [NUM_BLOCKS-1:0] lock_q;

  wire accept   = cmd_valid && en_q && !stop_q && !busy_q;
  wire arr_cmd  = (cmd_op == OP_PROG) || (cmd_op == OP_ERASE);
  wire blocked  = arr_cmd && !lock_q[cmd_blk] && !lkoff_q;

  assign reg_rdata      = {lstat_q, eerr_q, perr_q, !busy_q, user_q, stop_q, lkoff_q, en_q};
  assign read_user_area = user_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {user_q, stop_q, lkoff_q, en_q} <= '0;
      busy_q    <= 1'b0;
      arr_start <= 1'b0;
      arr_op    <= OP_PROG;
      arr_blk   <= '0;
      perr_q    <= 1'b0;
      eerr_q    <= 1'b0;
      lstat_q   <= 1'b0;
      unlock_q  <= 1'b0;
      lock_q    <= '1;
    end else begin
      arr_start <= 1'b0;
      if (reg_we) {user_q, stop_q, lkoff_q, en_q} <= reg_wdata;
      if (stop_q) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (arr_done) begin
          busy_q <= 1'b0;
          case (arr_op)
            OP_PROG:  perr_q <= arr_fail;
            OP_ERASE: begin
              eerr_q <= arr_fail;
              if (!arr_fail && unlock_q) lock_q[arr_blk] <= 1'b1;
            end
            default: begin
              if (arr_fail) perr_q <= 1'b1;
              else          lock_q[arr_blk] <= 1'b0;
            end
          endcase
        end
      end else if (accept) begin
        if (cmd_op == OP_QUERY) begin
          lstat_q <= lock_q[cmd_blk];
        end else if (!arr_cmd || user_q) begin
          if (cmd_op == OP_PROG)  perr_q <= blocked;
          if (cmd_op == OP_ERASE) eerr_q <= blocked;
          if (!blocked) begin
            busy_q    <= 1'b1;
            arr_start <= 1'b1;
            arr_op    <= cmd_op;
            arr_blk   <= cmd_blk;
            unlock_q  <= lkoff_q;
          end
        end
      end
    end
  end
endmodule

module flash_ctrl_seq_chk #(
  parameter int NUM_BLOCKS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_q,
  input logic                  stop_q,
  input logic                  busy_q,
  input logic                  arr_start,
  input logic                  arr_done,
  input logic [NUM_BLOCKS-1:0] lock_q
);
  // R3
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> !arr_start);
  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_q |=> (!busy_q && !arr_start));
  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) arr_start |=> !arr_start);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) arr_start |-> busy_q);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy_q && arr_done) |=> $stable(lock_q));
endmodule

bind flash_ctrl_seq flash_ctrl_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .stop_q(stop_q), .busy_q(busy_q),
  .arr_start(arr_start), .arr_done(arr_done), .lock_q(lock_q)
);

// File: tb/test_flash_ctrl_seq.sv
`timescale 1ns/1ps
module test_flash_ctrl_seq;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam logic [1:0] PROG = 2'd0, ERASE = 2'd1, LOCKP = 2'd2, QUERY = 2'd3;
  localparam int RDY = 4, PERR = 5, EERR = 6, LST = 7;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic read_user_area;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [BW-1:0] cmd_blk = 0;
  logic arr_start;
  logic [1:0] arr_op;
  logic [BW-1:0] arr_blk;
  logic arr_done = 0, arr_fail = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_ctrl_seq #(.NUM_BLOCKS(NB)) i_flash_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .read_user_area(read_user_area),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .arr_start(arr_start), .arr_op(arr_op), .arr_blk(arr_blk),
    .arr_done(arr_done), .arr_fail(arr_fail));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic write_ctrl(input logic [3:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [BW-1:0] b);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_blk = b;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic done(input bit f);
    @(negedge clk); arr_done = 1; arr_fail = f;
    @(negedge clk); arr_done = 0; arr_fail = 0;
  endtask

  task automatic query(input logic [BW-1:0] b, input bit exp, input string req);
    issue(QUERY, b);
    chk_eq(req, reg_rdata[LST], exp);
    chk_eq(req, arr_start, 0);
  endtask

  task automatic t_reset;
    chk_eq("R1 status", reg_rdata, 8'h10);
    write_ctrl(4'h1);
    for (int b = 0; b < NB; b++) query(b[BW-1:0], 1'b1, "R1 lock reset");
  endtask

  task automatic t_gate;
    write_ctrl(4'h8);
    chk_eq("R4 area out", read_user_area, 1);
    issue(PROG, 3'd0);
    chk_eq("R3 rewrite off", arr_start, 0);
    chk_eq("R3 ready", reg_rdata[RDY], 1);
    write_ctrl(4'h1);
    chk_eq("R4 area out boot", read_user_area, 0);
    issue(ERASE, 3'd1);
    chk_eq("R4 boot area", arr_start, 0);
    chk_eq("R4 ready", reg_rdata[RDY], 1);
  endtask

  task automatic t_program;
    write_ctrl(4'h9);
    chk_eq("R2 ctrl bits", reg_rdata[3:0], 4'h9);
    issue(PROG, 3'd2);
    chk_eq("R13 start", arr_start, 1);
    chk_eq("R13 op", arr_op, PROG);
    chk_eq("R13 blk", arr_blk, 2);
    chk_eq("R2 busy", reg_rdata[RDY], 0);
    issue(ERASE, 3'd5);
    chk_eq("R13 one cycle", arr_start, 0);
    chk_eq("R11 drop", arr_start, 0);
    done(1'b1);
    chk_eq("R2 ready after done", reg_rdata[RDY], 1);
    chk_eq("R10 prog err", reg_rdata[PERR], 1);
    chk_eq("R10 erase err untouched", reg_rdata[EERR], 0);
    issue(PROG, 3'd2);
    chk_eq("R10 clear on issue", reg_rdata[PERR], 0);
    chk_eq("R13 restart blk", arr_blk, 2);
    done(1'b0);
    chk_eq("R10 ok", reg_rdata[PERR], 0);
    issue(ERASE, 3'd6);
    chk_eq("R13 erase op", arr_op, ERASE);
    done(1'b1);
    chk_eq("R10 erase err", reg_rdata[EERR], 1);
    chk_eq("R11 dropped erase never ran", reg_rdata[RDY], 1);
  endtask

  task automatic t_lock;
    issue(LOCKP, 3'd3);
    chk_eq("R8 start op", arr_op, LOCKP);
    done(1'b0);
    query(3'd3, 1'b0, "R8 locked");
    query(3'd4, 1'b1, "R9 other unlocked");
    issue(LOCKP, 3'd5);
    done(1'b1);
    chk_eq("R8 fail err", reg_rdata[PERR], 1);
    query(3'd5, 1'b1, "R8 fail keeps");
    issue(PROG, 3'd3);
    chk_eq("R5 no start", arr_start, 0);
    chk_eq("R5 ready", reg_rdata[RDY], 1);
    chk_eq("R5 prog err", reg_rdata[PERR], 1);
    issue(ERASE, 3'd3);
    chk_eq("R5 no erase start", arr_start, 0);
    chk_eq("R5 erase err", reg_rdata[EERR], 1);
    issue(ERASE, 3'd4);
    chk_eq("R10 erase err cleared", reg_rdata[EERR], 0);
    done(1'b0);
    query(3'd3, 1'b0, "R5 lock kept");
  endtask

  task automatic t_override;
    write_ctrl(4'hB);
    query(3'd3, 1'b0, "R6 override keeps lock");
    issue(PROG, 3'd3);
    chk_eq("R6 start", arr_start, 1);
    done(1'b0);
    query(3'd3, 1'b0, "R6 program no unlock");
    issue(ERASE, 3'd3);
    chk_eq("R6 erase start", arr_start, 1);
    done(1'b1);
    query(3'd3, 1'b0, "R7 failed erase keeps");
    issue(ERASE, 3'd3);
    done(1'b0);
    query(3'd3, 1'b1, "R7 unlocked");
    write_ctrl(4'h9);
    issue(PROG, 3'd3);
    chk_eq("R7 now startable", arr_start, 1);
    done(1'b0);
  endtask

  task automatic t_stop;
    issue(PROG, 3'd1);
    chk_eq("R12 busy", reg_rdata[RDY], 0);
    write_ctrl(4'hD);
    @(negedge clk);
    chk_eq("R12 forced ready", reg_rdata[RDY], 1);
    issue(ERASE, 3'd1);
    chk_eq("R3 stop blocks", arr_start, 0);
    done(1'b1);
    chk_eq("R12 late done ignored", reg_rdata[PERR], 0);
    write_ctrl(4'h9);
    issue(PROG, 3'd1);
    chk_eq("R12 resumes", arr_start, 1);
    done(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_program;
    t_lock;
    t_override;
    t_stop;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule